// File: doc/BRIEF.md
# Shared Receive/Transmit Descriptor Ring Sequencer

This block manages one channel's ring of 8-byte buffer descriptors in switching mode, where the receive and transmit sides use the same ring. The receive side reports each received packet through an event input. The sequencer then reads the descriptor at its receive index and rewrites the descriptor's status and header half-words. A complete or failed packet moves the receive index on. A partial packet leaves the index where it is and records the channel code, so the rest of the packet can land in the same descriptor when the next cell arrives.

The transmit side asks for the next descriptor by holding a request. The sequencer delivers completed descriptors in ring order. It skips any descriptor whose packet failed and never runs ahead of the receive side. Ring length is set only by the wrap bit that software places in a descriptor's status. If a walk reaches the largest ring the address space allows without meeting a wrap bit, a sticky configuration error is raised.

Each descriptor has an interrupt bit, and a per-queue enable input gates it. A failed receive also pushes an error entry for the interrupt queue.

Top module: `dring_seq`

## Requirements
- R1: On synchronous reset (rst_n low at a clock edge), rx_idx and tx_idx become 0, rx_evt_ready is 1, and cfg_err, rx_stuck, irq, iq_push, tx_adv_ack and tx_skip are 0.
- R2: The status half-word sits at byte offset 0 of a descriptor, and its fields are:
  - bit 15: error flag
  - bit 13: wrap
  - bit 12: interrupt enable
  - bit 8: uncompleted-packet flag
  - bits 7:0: header start byte

  Every status write keeps bits 13 and 12 as read and writes bits 14 and 11:9 as zero.
- R3: An event of kind 0 (partial) writes a status with error 0 and uncompleted 1. It writes rx_evt_hdr_rest, which here carries the channel code, to the header half-word at offset 2. It leaves rx_idx unchanged and sets rx_stuck.
- R4: An event of kind 1 (complete) writes a status with error 0 and uncompleted 0. It writes rx_evt_hdr_rest to offset 2, advances rx_idx and clears rx_stuck.
- R5: An event of kind 2 or 3 (failed) writes a status with error 1 and uncompleted 1, and advances rx_idx. It also pulses iq_push with iq_etype equal to rx_evt_etype. iq_cid equals rx_evt_cid, except that iq_cid is 0 when the error type is 1 (header check failure).
- R6: After a descriptor whose wrap bit is set, the next index is 0. Otherwise the next index is the current index plus 1.
- R7: When an index at RING_BYTES/8-1 is left with no wrap bit, cfg_err is set and stays set until reset, and the index goes to 0.
- R8: irq pulses for one cycle for a complete or failed event only when the descriptor's interrupt bit and cfg_irq_en are both 1. It never pulses for a partial event.
- R9: Each tx_adv_ack pulse presents the next completed, non-failed descriptor in ring order on tx_desc_idx, and tx_idx then advances past it.
- R10: A completed descriptor with both error and uncompleted set is passed over with a tx_skip pulse and never acknowledged. tx_adv_ack and tx_skip are never high together.
- R11: When no completed descriptor is outstanding, a held tx_adv_req gets no acknowledgement and tx_idx does not move.
- R12: The sequencer never writes byte offsets 4 to 7 of a descriptor, so the buffer pointer stays untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_irq_en | input | 1 | Per-queue interrupt enable |
| rx_evt_valid | input | 1 | Receive packet event offered |
| rx_evt_ready | output | 1 | Sequencer idle, event accepted this cycle |
| rx_evt_kind | input | 2 | 0 partial, 1 complete, 2/3 failed |
| rx_evt_hdr_start | input | 8 | First header byte |
| rx_evt_hdr_rest | input | 16 | Header remainder, or channel code when partial |
| rx_evt_cid | input | 8 | Channel ID for error entries |
| rx_evt_etype | input | 4 | Error type for failed packets |
| tx_adv_req | input | 1 | Transmit wants the next descriptor |
| tx_adv_ack | output | 1 | Descriptor delivered to transmit |
| tx_skip | output | 1 | Failed descriptor passed over |
| tx_desc_idx | output | IDX_W | Index of descriptor being acknowledged or skipped |
| mem_req | output | 1 | Descriptor memory access |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | ADDR_W | Byte address within the ring |
| mem_wdata | output | 16 | Write half-word |
| mem_rdata | input | 16 | Read half-word, valid the cycle after a read |
| rx_idx | output | IDX_W | Receive index |
| tx_idx | output | IDX_W | Transmit index |
| rx_stuck | output | 1 | Partial packet waiting for its remainder |
| cfg_err | output | 1 | Ring overran the size limit without a wrap bit |
| irq | output | 1 | Interrupt pulse |
| iq_push | output | 1 | Interrupt queue error entry valid |
| iq_cid | output | 8 | Entry channel ID |
| iq_etype | output | 4 | Entry error type |

## Verification
Several properties are checked on every cycle:
- reserved status bits are zero on each status write;
- the pointer half-words are never written;
- the index restarts at 0 after a wrap;
- cfg_err is sticky;
- irq is masked by the enable;
- header-check error entries carry channel ID 0;
- tx_idx is frozen while no completed descriptor is outstanding;
- acknowledge and skip are exclusive.

Other behaviour only shows up in the bench scenarios: the exact status and header contents, ring-order delivery across many laps, the skipping of failed descriptors, and the overrun of a ring that has no wrap bit. The bench checks these against its own model of the ring.

// File: rtl/dring_pkg.sv
package dring_pkg;

  typedef enum logic [1:0] {
    EVT_PART = 2'd0,
    EVT_DONE = 2'd1,
    EVT_FAIL = 2'd2,
    EVT_FAIL_ALT = 2'd3
  } evt_kind_e;

  localparam int STAT_ERR_BIT  = 15;
  localparam int STAT_WRAP_BIT = 13;
  localparam int STAT_INTR_BIT = 12;
  localparam int STAT_UP_BIT   = 8;
  localparam logic [15:0] STAT_RSVD_MASK = 16'h4E00;
  localparam logic [3:0]  ETYPE_HDR_CHECK = 4'h1;
  localparam logic [2:0]  OFS_STATUS = 3'd0;
  localparam logic [2:0]  OFS_HEADER = 3'd2;

  function automatic logic [15:0] pack_status(input logic err, input logic up,
                                              input logic wrap, input logic intr,
                                              input logic [7:0] hstart);
    logic [15:0] s;
    s = '0;
    s[STAT_ERR_BIT]  = err;
    s[STAT_WRAP_BIT] = wrap;
    s[STAT_INTR_BIT] = intr;
    s[STAT_UP_BIT]   = up;
    s[7:0]           = hstart;
    return s;
  endfunction

  function automatic logic status_failed(input logic [15:0] s);
    return s[STAT_ERR_BIT] & s[STAT_UP_BIT];
  endfunction

endpackage

// File: rtl/dring_step.sv
module dring_step #(
  parameter int IDX_W    = 13,
  parameter int MAX_DESC = 8192
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             wrap,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             overrun
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_DESC - 1);

  always_comb begin
    overrun = 1'b0;
    if (wrap) begin
      nxt_idx = '0;
    end else if (cur_idx == LAST_IDX) begin
      nxt_idx = '0;
      overrun = 1'b1;
    end else begin
      nxt_idx = cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/dring_stat_fmt.sv
module dring_stat_fmt
  import dring_pkg::*;
(
  input  logic [1:0]  kind,
  input  logic [15:0] rd_status,
  input  logic [7:0]  hstart,
  output logic [15:0] wr_status,
  output logic        commit,
  output logic        failed
);
  always_comb begin
    commit    = (kind != EVT_PART);
    failed    = (kind == EVT_FAIL) || (kind == EVT_FAIL_ALT);
    wr_status = pack_status(failed, failed | ~commit,
                            rd_status[STAT_WRAP_BIT], rd_status[STAT_INTR_BIT],
                            hstart);
  end
endmodule

// File: rtl/dring_irq_gate.sv
module dring_irq_gate
  import dring_pkg::*;
(
  input  logic       fire,
  input  logic       failed,
  input  logic       desc_intr,
  input  logic       irq_en,
  input  logic [7:0] cid,
  input  logic [3:0] etype,
  output logic       irq,
  output logic       iq_push,
  output logic [7:0] iq_cid,
  output logic [3:0] iq_etype
);
  always_comb begin
    irq      = fire & desc_intr & irq_en;
    iq_push  = fire & failed;
    iq_etype = etype;
    iq_cid   = (etype == ETYPE_HDR_CHECK) ? 8'h00 : cid;
  end
endmodule

// File: rtl/dring_seq.sv
module dring_seq
  import dring_pkg::*;
#(
  parameter  int RING_BYTES = 65536,
  localparam int MAX_DESC   = RING_BYTES / 8,
  localparam int IDX_W      = $clog2(MAX_DESC),
  localparam int ADDR_W     = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_irq_en,
  input  logic              rx_evt_valid,
  output logic              rx_evt_ready,
  input  logic [1:0]        rx_evt_kind,
  input  logic [7:0]        rx_evt_hdr_start,
  input  logic [15:0]       rx_evt_hdr_rest,
  input  logic [7:0]        rx_evt_cid,
  input  logic [3:0]        rx_evt_etype,
  input  logic              tx_adv_req,
  output logic              tx_adv_ack,
  output logic              tx_skip,
  output logic [IDX_W-1:0]  tx_desc_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic [IDX_W-1:0]  rx_idx,
  output logic [IDX_W-1:0]  tx_idx,
  output logic              rx_stuck,
  output logic              cfg_err,
  output logic              irq,
  output logic              iq_push,
  output logic [7:0]        iq_cid,
  output logic [3:0]        iq_etype
);
  localparam int OCC_W = IDX_W + 1;
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(MAX_DESC);

  typedef enum logic [2:0] {
    S_IDLE, S_RX_RD, S_RX_WS, S_RX_WH, S_TX_RD, S_TX_EV
  } seq_st_e;

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] rx_idx_q, tx_idx_q;
  logic [OCC_W-1:0] occ_q;
  logic             cfg_err_q, rx_stuck_q;
  logic [1:0]       ev_kind_q;
  logic [7:0]       ev_hstart_q, ev_cid_q;
  logic [15:0]      ev_rest_q;
  logic [3:0]       ev_etype_q;
  logic             lat_wrap_q, lat_intr_q;

  // named internal events
  logic             rx_accept, tx_start, rx_fire, rx_commit, tx_eval;
  logic             tx_fail;
  logic [15:0]      wr_status;
  logic             fmt_commit, fmt_failed;

  // index steppers: side 0 receive, side 1 transmit
  logic [IDX_W-1:0] step_cur [2];
  logic             step_wrap [2];
  logic [IDX_W-1:0] step_nxt [2];
  logic             step_ovr [2];

  assign step_cur[0]  = rx_idx_q;
  assign step_wrap[0] = lat_wrap_q;
  assign step_cur[1]  = tx_idx_q;
  assign step_wrap[1] = mem_rdata[STAT_WRAP_BIT];

  for (genvar g = 0; g < 2; g++) begin : g_step
    dring_step #(.IDX_W(IDX_W), .MAX_DESC(MAX_DESC)) u_step (
      .cur_idx (step_cur[g]),
      .wrap    (step_wrap[g]),
      .nxt_idx (step_nxt[g]),
      .overrun (step_ovr[g])
    );
  end

  dring_stat_fmt u_fmt (
    .kind      (ev_kind_q),
    .rd_status (mem_rdata),
    .hstart    (ev_hstart_q),
    .wr_status (wr_status),
    .commit    (fmt_commit),
    .failed    (fmt_failed)
  );

  assign rx_accept = (st_q == S_IDLE) && rx_evt_valid;
  assign tx_start  = (st_q == S_IDLE) && !rx_evt_valid && tx_adv_req && (occ_q != '0);
  assign rx_fire   = (st_q == S_RX_WH);
  assign rx_commit = rx_fire && fmt_commit;
  assign tx_eval   = (st_q == S_TX_EV);
  assign tx_fail   = status_failed(mem_rdata);

  dring_irq_gate u_irq (
    .fire      (rx_commit),
    .failed    (fmt_failed),
    .desc_intr (lat_intr_q),
    .irq_en    (cfg_irq_en),
    .cid       (ev_cid_q),
    .etype     (ev_etype_q),
    .irq       (irq),
    .iq_push   (iq_push),
    .iq_cid    (iq_cid),
    .iq_etype  (iq_etype)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (rx_accept) st_d = S_RX_RD;
               else if (tx_start) st_d = S_TX_RD;
      S_RX_RD: st_d = S_RX_WS;
      S_RX_WS: st_d = S_RX_WH;
      S_RX_WH: st_d = S_IDLE;
      S_TX_RD: st_d = S_TX_EV;
      S_TX_EV: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      S_RX_RD: begin
        mem_req  = 1'b1;
        mem_addr = {rx_idx_q, OFS_STATUS};
      end
      S_RX_WS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {rx_idx_q, OFS_STATUS};
        mem_wdata = wr_status;
      end
      S_RX_WH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {rx_idx_q, OFS_HEADER};
        mem_wdata = ev_rest_q;
      end
      S_TX_RD: begin
        mem_req  = 1'b1;
        mem_addr = {tx_idx_q, OFS_STATUS};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      rx_idx_q    <= '0;
      tx_idx_q    <= '0;
      occ_q       <= '0;
      cfg_err_q   <= 1'b0;
      rx_stuck_q  <= 1'b0;
      ev_kind_q   <= EVT_PART;
      ev_hstart_q <= '0;
      ev_rest_q   <= '0;
      ev_cid_q    <= '0;
      ev_etype_q  <= '0;
      lat_wrap_q  <= 1'b0;
      lat_intr_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (rx_accept) begin
        ev_kind_q   <= rx_evt_kind;
        ev_hstart_q <= rx_evt_hdr_start;
        ev_rest_q   <= rx_evt_hdr_rest;
        ev_cid_q    <= rx_evt_cid;
        ev_etype_q  <= rx_evt_etype;
      end
      if (st_q == S_RX_WS) begin
        lat_wrap_q <= mem_rdata[STAT_WRAP_BIT];
        lat_intr_q <= mem_rdata[STAT_INTR_BIT];
      end
      if (rx_fire) begin
        if (rx_commit) begin
          rx_idx_q   <= step_nxt[0];
          rx_stuck_q <= 1'b0;
          if (occ_q != OCC_FULL) occ_q <= occ_q + 1'b1;
          if (step_ovr[0]) cfg_err_q <= 1'b1;
        end else begin
          rx_stuck_q <= 1'b1;
        end
      end
      if (tx_eval) begin
        tx_idx_q <= step_nxt[1];
        occ_q    <= occ_q - 1'b1;
        if (step_ovr[1]) cfg_err_q <= 1'b1;
      end
    end
  end

  assign rx_evt_ready = (st_q == S_IDLE);
  assign tx_adv_ack   = tx_eval && !tx_fail;
  assign tx_skip      = tx_eval && tx_fail;
  assign tx_desc_idx  = tx_idx_q;
  assign rx_idx       = rx_idx_q;
  assign tx_idx       = tx_idx_q;
  assign rx_stuck     = rx_stuck_q;
  assign cfg_err      = cfg_err_q;

endmodule

// File: rtl/dring_seq_chk.sv
module dring_seq_chk
  import dring_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int OCC_W  = 14,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_irq_en,
  input logic              irq,
  input logic              iq_push,
  input logic [7:0]        iq_cid,
  input logic [3:0]        iq_etype,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic [IDX_W-1:0]  rx_idx,
  input logic [IDX_W-1:0]  tx_idx,
  input logic              cfg_err,
  input logic              tx_adv_ack,
  input logic              tx_skip,
  input logic              rx_commit,
  input logic              lat_wrap_q,
  input logic [OCC_W-1:0]  occ_q
);
  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[2:0] == OFS_STATUS) |-> ((mem_wdata & STAT_RSVD_MASK) == 16'h0)); // R2
  AST_PTR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_addr[2]); // R12
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_commit && lat_wrap_q) |=> (rx_idx == '0)); // R6
  AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_irq_en); // R8
  AST_HDR_CHECK_CID: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_push && iq_etype == ETYPE_HDR_CHECK) |-> (iq_cid == 8'h00)); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) |=> $stable(tx_idx)); // R11
  AST_ACK_SKIP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_adv_ack && tx_skip)); // R10
endmodule

bind dring_seq dring_seq_chk #(.IDX_W(IDX_W), .OCC_W(OCC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_irq_en (cfg_irq_en),
  .irq        (irq),
  .iq_push    (iq_push),
  .iq_cid     (iq_cid),
  .iq_etype   (iq_etype),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .rx_idx     (rx_idx),
  .tx_idx     (tx_idx),
  .cfg_err    (cfg_err),
  .tx_adv_ack (tx_adv_ack),
  .tx_skip    (tx_skip),
  .rx_commit  (rx_commit),
  .lat_wrap_q (lat_wrap_q),
  .occ_q      (occ_q)
);

// File: tb/dring_seq_bench.sv
module dring_seq_bench;
  localparam int RB = 256;
  localparam int ND = RB / 8;
  localparam int IW = $clog2(ND);
  localparam int AW = IW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_irq_en = 1'b0;
  logic rx_evt_valid = 1'b0;
  logic rx_evt_ready;
  logic [1:0] rx_evt_kind = '0;
  logic [7:0] rx_evt_hdr_start = '0;
  logic [15:0] rx_evt_hdr_rest = '0;
  logic [7:0] rx_evt_cid = '0;
  logic [3:0] rx_evt_etype = '0;
  logic tx_adv_req = 1'b0;
  logic tx_adv_ack, tx_skip;
  logic [IW-1:0] tx_desc_idx, rx_idx, tx_idx;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic rx_stuck, cfg_err, irq, iq_push;
  logic [7:0] iq_cid;
  logic [3:0] iq_etype;

  always #5 clk = ~clk;

  dring_seq #(.RING_BYTES(RB)) u_dring_seq (
    .clk(clk), .rst_n(rst_n), .cfg_irq_en(cfg_irq_en),
    .rx_evt_valid(rx_evt_valid), .rx_evt_ready(rx_evt_ready),
    .rx_evt_kind(rx_evt_kind), .rx_evt_hdr_start(rx_evt_hdr_start),
    .rx_evt_hdr_rest(rx_evt_hdr_rest), .rx_evt_cid(rx_evt_cid),
    .rx_evt_etype(rx_evt_etype), .tx_adv_req(tx_adv_req),
    .tx_adv_ack(tx_adv_ack), .tx_skip(tx_skip), .tx_desc_idx(tx_desc_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_idx(rx_idx),
    .tx_idx(tx_idx), .rx_stuck(rx_stuck), .cfg_err(cfg_err), .irq(irq),
    .iq_push(iq_push), .iq_cid(iq_cid), .iq_etype(iq_etype)
  );

  logic [15:0] dmem [0:4*ND-1];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) dmem[mem_addr[AW-1:1]] <= mem_wdata;
      else mem_rdata <= dmem[mem_addr[AW-1:1]];
    end
  end

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;

  // bench model of the ring
  int ring_len;
  bit w_bit [ND];
  bit i_bit [ND];
  bit fail_m [ND];
  int m_rx, m_tx, m_occ;

  task automatic check_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int nx(input int i);
    if (ring_len > 0 && i == ring_len - 1) return 0;
    if (i == ND - 1) return 0;
    return i + 1;
  endfunction

  function automatic logic [15:0] exp_stat(input int kind, input bit w, input bit it,
                                           input logic [7:0] hs);
    bit f;
    bit u;
    f = (kind >= 2);
    u = (kind != 1);
    return {f, 1'b0, w, it, 3'b000, u, hs};
  endfunction

  task automatic init_ring(input int len);
    ring_len = len;
    for (int i = 0; i < ND; i++) begin
      w_bit[i] = (len > 0) && (i == len - 1);
      i_bit[i] = $urandom % 2;
      fail_m[i] = 0;
      dmem[4*i]   = {2'b00, w_bit[i], i_bit[i], 12'h000};
      dmem[4*i+1] = 16'h0000;
      dmem[4*i+2] = 16'hA000 | 16'(i);
      dmem[4*i+3] = 16'h5000 | 16'(i);
    end
    m_rx = 0; m_tx = 0; m_occ = 0;
  endtask

  task automatic set_intr(input int i, input bit v);
    i_bit[i] = v;
    dmem[4*i][12] = v;
  endtask

  task automatic do_rx(input int kind, input logic [7:0] hs, input logic [15:0] rest,
                       input logic [7:0] cid, input logic [3:0] et);
    int n_irq;
    int n_iq;
    logic [7:0] got_cid;
    logic [3:0] got_et;
    int d;
    n_irq = 0; n_iq = 0; got_cid = '0; got_et = '0;
    d = m_rx;
    @(negedge clk);
    rx_evt_valid = 1'b1; rx_evt_kind = 2'(kind); rx_evt_hdr_start = hs;
    rx_evt_hdr_rest = rest; rx_evt_cid = cid; rx_evt_etype = et;
    while (!rx_evt_ready) @(negedge clk);
    @(negedge clk);
    rx_evt_valid = 1'b0;
    while (!rx_evt_ready) begin
      if (irq) n_irq++;
      if (iq_push) begin n_iq++; got_cid = iq_cid; got_et = iq_etype; end
      @(negedge clk);
    end
    // R2 R3 R4 R5: descriptor contents
    check_eq("R2", "status half-word", dmem[4*d], exp_stat(kind, w_bit[d], i_bit[d], hs));
    check_eq(kind == 0 ? "R3" : "R4", "header half-word", dmem[4*d+1], rest);
    // R8
    check_eq("R8", "irq pulses", n_irq, (kind != 0 && i_bit[d] && cfg_irq_en) ? 1 : 0);
    // R5
    check_eq("R5", "queue entries", n_iq, (kind >= 2) ? 1 : 0);
    if (kind >= 2) begin
      check_eq("R5", "entry cid", got_cid, (et == 4'h1) ? 8'h00 : cid);
      check_eq("R5", "entry etype", got_et, et);
    end
    if (kind != 0) begin
      fail_m[d] = (kind >= 2);
      m_rx = nx(d);
      if (m_occ < ND) m_occ++;
    end
    check_eq(kind == 0 ? "R3" : "R6", "rx_idx", rx_idx, m_rx);
    check_eq(kind == 0 ? "R3" : "R4", "rx_stuck", rx_stuck, (kind == 0) ? 1 : 0);
  endtask

  task automatic do_tx();
    int ex_skips;
    bit ex_ack;
    int ex_idx;
    int t;
    int o;
    int g_skips;
    bit g_ack;
    int g_idx;
    ex_skips = 0; ex_ack = 0; ex_idx = 0; t = m_tx; o = m_occ;
    while (o > 0 && fail_m[t]) begin ex_skips++; t = nx(t); o--; end
    if (o > 0) begin ex_ack = 1; ex_idx = t; t = nx(t); o--; end
    m_tx = t; m_occ = o;
    g_skips = 0; g_ack = 0; g_idx = 0;
    @(negedge clk);
    tx_adv_req = 1'b1;
    for (int c = 0; c < 40 && !g_ack; c++) begin
      @(negedge clk);
      if (tx_skip) g_skips++;
      if (tx_adv_ack) begin g_ack = 1; g_idx = tx_desc_idx; tx_adv_req = 1'b0; end
    end
    tx_adv_req = 1'b0;
    @(negedge clk);
    check_eq(ex_ack ? "R9" : "R11", "ack seen", g_ack, ex_ack);
    if (ex_ack) check_eq("R9", "acked index", g_idx, ex_idx);
    check_eq("R10", "skip count", g_skips, ex_skips);
    check_eq("R9", "tx_idx", tx_idx, m_tx);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    init_ring(6);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1", "rx_idx", rx_idx, 0);
    check_eq("R1", "tx_idx", tx_idx, 0);
    check_eq("R1", "ready", rx_evt_ready, 1);
    check_eq("R1", "cfg_err", cfg_err, 0);
    check_eq("R1", "rx_stuck", rx_stuck, 0);
    check_eq("R1", "irq", irq, 0);
    check_eq("R1", "iq_push", iq_push, 0);

    // R11: nothing outstanding, request must be held off
    do_tx();

    // R8: interrupt bit set but enable low, then both set
    set_intr(0, 1); set_intr(1, 1);
    cfg_irq_en = 1'b0;
    do_rx(1, 8'h11, 16'h2222, 8'h05, 4'h0);
    cfg_irq_en = 1'b1;
    do_rx(1, 8'h12, 16'h2323, 8'h05, 4'h0);
    // R3 partial then R5 header-check failure on same descriptor
    do_rx(0, 8'h40, 16'h00C7, 8'h33, 4'h0);
    do_rx(2, 8'h41, 16'h1111, 8'h33, 4'h1);
    // R5 other error type keeps cid
    do_rx(3, 8'h42, 16'h1212, 8'h34, 4'h2);
    // R10 deliver two then skip two failed
    do_tx(); do_tx(); do_tx();

    for (int it = 0; it < 300; it++) begin
      int r;
      r = $urandom % 4;
      if (it % 60 == 0) cfg_irq_en = $urandom % 2;
      if (r < 2 && m_occ < ring_len - 1) begin
        int k;
        int kr;
        kr = $urandom % 8;
        k = (kr < 2) ? 0 : (kr < 6) ? 1 : (kr == 6) ? 2 : 3;
        do_rx(k, 8'($urandom), 16'($urandom), 8'($urandom % 255 + 1), 4'($urandom % 4));
      end else begin
        do_tx();
      end
    end
    while (m_occ > 0) do_tx();

    // R12 pointer words untouched
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < ND; i++)
        if (dmem[4*i+2] !== (16'hA000 | 16'(i)) || dmem[4*i+3] !== (16'h5000 | 16'(i))) bad++;
      check_eq("R12", "pointer words altered", bad, 0);
    end

    // R7 ring without any wrap bit
    @(negedge clk);
    rst_n = 1'b0;
    init_ring(0);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < ND; k++) begin
      do_rx(1, 8'(k), 16'(k), 8'h01, 4'h0);
      if (k == ND - 2) begin
        check_eq("R7", "cfg_err before limit", cfg_err, 0);
        check_eq("R7", "rx_idx at last", rx_idx, ND - 1);
      end
    end
    check_eq("R7", "cfg_err after limit", cfg_err, 1);
    check_eq("R7", "rx_idx after limit", rx_idx, 0);
    repeat (3) @(negedge clk);
    check_eq("R7", "cfg_err sticky", cfg_err, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "cfg_err cleared by reset", cfg_err, 0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule